// File: doc/BRIEF.md
# Serial Flash Clock and Chip-Select Timing Generator

This block derives a serial flash clock and a set of active-low chip-select pins from a faster reference clock. A transfer engine requests a transaction with a one-cycle start strobe and a bit count. The block then frames that transaction. It can first hold all selects high to separate accesses to different devices. It then drives the chosen select low and waits before the first clock edge. It toggles the clock for the requested number of bits, waits after the last edge, and raises the select. Finally it enforces a minimum high time on the select before it reports idle again.

Configuration arrives as two words. The control word carries an enable bit, a select-encoding bit, a 4-bit device field and a 4-bit clock divisor. The delay word carries four 8-bit counts in reference-clock ticks. The block captures both words when it accepts a start, so software may rewrite them while a transaction runs. The read-back word shows the control word with the live idle flag in its top bit. The serial clock idles low and every select idles high.

Top module: `sfc_sel_timer`

## Requirements
- R1: After reset `idle` is 1, `cs_n` is 4'hF, `sclk` is 0 and `cfg_rd[31]` is 1.
- R2: With divisor N = `cfg_in[22:19]`, each high and each low half of `sclk` lasts N+1 reference ticks, which gives a period of 2(N+1) ticks.
- R3: A transaction produces exactly `nbits_m1`+1 rising edges on `sclk`, so a value of 0 means one bit.
- R4: When `cfg_in[9]` is 0, a device number k of 0..3 in `cfg_in[13:10]` drives `cs_n[k]` low and the other pins high while the device is selected. At most one pin is ever low in this mode.
- R5: When `cfg_in[9]` is 1, the device field is driven unchanged onto `cs_n` as a binary code for an external decoder while the device is selected. Codes 0..14 are usable, because 4'hF means that nothing is selected.
- R6: Let A be `dly_in[7:0]`. The select is low for max(A,1) ticks with `sclk` low before the first clock half begins, so the first rising edge comes max(A,1)+N+1 ticks after the select falls.
- R7: Let B be `dly_in[15:8]`. The select stays low for max(A,1) + 2(`nbits_m1`+1)(N+1) + max(B,1) ticks in total, which includes a trailing hold of max(B,1) ticks after the last falling edge.
- R8: Let S be `dly_in[23:16]`. When the device identity (the encoding bit together with the device field) differs from the previous accepted transaction, max(S,1) ticks with all selects high pass between acceptance and the select falling. For the same device, or for the first transaction after reset, the select falls on the first tick.
- R9: Let D be `dly_in[31:24]`. After the select rises, `idle` returns to 1 only after max(D, 2(N+1)) ticks, so the select stays high for at least one full serial clock period.
- R10: `idle` and `cfg_rd[31]` are 0 from the cycle after a start is accepted until the deselect time has elapsed. At all other times they are 1. `cfg_rd[30:0]` echoes `cfg_in`.
- R11: A start is accepted only while `idle` is 1 and the enable bit `cfg_in[0]` is 1. Clearing the enable bit during a transaction lets that transaction finish unchanged, and later starts are then ignored, with selects held high and `sclk` low.
- R12: Changes to `cfg_in` or `dly_in` after acceptance have no effect on the running transaction.
- R13: `sclk` is high only during the clocking phase. While idle, `sclk` is low and `cs_n` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_in | input | 31 | Control word: enable [0], encoding [9], device [13:10], divisor [22:19] |
| dly_in | input | 32 | Four 8-bit tick counts: lead [7:0], trail [15:8], device switch [23:16], deselect [31:24] |
| start | input | 1 | Start strobe for one transaction |
| nbits_m1 | input | LEN_W | Number of bits minus one |
| sclk | output | 1 | Serial flash clock, idles low |
| cs_n | output | 4 | Active-low selects or decoder code |
| idle | output | 1 | No transaction or deselect wait is pending |
| cfg_rd | output | 32 | Read-back word: idle flag at [31], control word below it |

## Verification
The assertions check several properties on every cycle. They confirm that `sclk` is high only during the clocking phase and that the outputs stay quiet while idle. They confirm that at most one select pin is low in one-hot mode and that the select pattern never changes while a device is selected. They also confirm that every high half of `sclk` lasts exactly N+1 ticks and that the deselect wait is never shorter than one serial period. Some behaviour can only be shown by the bench's scenarios: the counted phase lengths for each delay, the number of clock edges, the extra gap that appears only when the device changes, and the way the block ignores configuration changes and a cleared enable during a transaction.

// File: rtl/sfc_sel_timer_pkg.sv
package sfc_sel_timer_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SWITCH = 3'd1,
    PH_LEAD   = 3'd2,
    PH_CLOCK  = 3'd3,
    PH_TRAIL  = 3'd4,
    PH_GAP    = 3'd5
  } phase_t;
endpackage

// File: rtl/sfc_clk_gen.sv
module sfc_clk_gen #(
  parameter int BAUD_W = 4,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              run,
  input  logic [BAUD_W:0]   half,
  input  logic [LEN_W:0]    nbits,
  output logic              sclk,
  output logic              done
);
  localparam int EDGE_W = LEN_W + 2;

  logic [BAUD_W:0]   half_cnt;
  logic [EDGE_W-1:0] edges_left;
  logic              half_end;

  assign half_end = (half_cnt == (BAUD_W+1)'(1));
  assign done     = run && half_end && (edges_left == EDGE_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_cnt   <= '0;
      edges_left <= '0;
      sclk       <= 1'b0;
    end else if (load) begin
      half_cnt   <= half;
      edges_left <= {nbits, 1'b0};
      sclk       <= 1'b0;
    end else if (run) begin
      if (half_end) begin
        sclk       <= ~sclk;
        half_cnt   <= half;
        edges_left <= edges_left - EDGE_W'(1);
      end else begin
        half_cnt <= half_cnt - (BAUD_W+1)'(1);
      end
    end else begin
      sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/sfc_sel_enc.sv
module sfc_sel_enc #(
  parameter int CS_W = 4
) (
  input  logic            active,
  input  logic            decode,
  input  logic [CS_W-1:0] sel,
  output logic [CS_W-1:0] cs_n
);
  logic [CS_W-1:0] onehot_n;

  for (genvar i = 0; i < CS_W; i++) begin : g_pin
    assign onehot_n[i] = !(active && (sel == CS_W'(i)));
  end

  always_comb begin
    if (decode) cs_n = active ? sel : '1;
    else        cs_n = onehot_n;
  end
endmodule

// File: rtl/sfc_frame_fsm.sv
module sfc_frame_fsm
  import sfc_sel_timer_pkg::*;
#(
  parameter int BAUD_W = 4,
  parameter int CS_W   = 4,
  parameter int DLY_W  = 8,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               start,
  input  logic [BAUD_W-1:0]  baud_in,
  input  logic [CS_W-1:0]    sel_in,
  input  logic               decode_in,
  input  logic [4*DLY_W-1:0] dly_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               clk_done,
  output phase_t             phase,
  output logic               load_clk,
  output logic [BAUD_W:0]    half,
  output logic [CS_W-1:0]    sel,
  output logic               decode,
  output logic [LEN_W:0]     nbits,
  output logic [CNT_W-1:0]   gap_min
);
  logic [4*DLY_W-1:0] dly_l;
  logic [CS_W:0]      last_id;
  logic               have_last;
  logic [CNT_W-1:0]   dcnt;
  logic               expired;
  logic [CS_W:0]      new_id;

  function automatic logic [CNT_W-1:0] at_least_one(input logic [DLY_W-1:0] d);
    return (d == '0) ? CNT_W'(1) : CNT_W'(d);
  endfunction

  function automatic logic [CNT_W-1:0] deselect_ticks(input logic [DLY_W-1:0] d,
                                                      input logic [BAUD_W:0] h);
    logic [CNT_W-1:0] period;
    period = CNT_W'({h, 1'b0});
    return (CNT_W'(d) > period) ? CNT_W'(d) : period;
  endfunction

  assign expired  = (dcnt <= CNT_W'(1));
  assign load_clk = (phase == PH_LEAD) && expired;
  assign gap_min  = deselect_ticks(dly_l[4*DLY_W-1:3*DLY_W], half);
  assign new_id   = {decode_in, sel_in};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      dcnt      <= '0;
      dly_l     <= '0;
      half      <= (BAUD_W+1)'(1);
      sel       <= '0;
      decode    <= 1'b0;
      nbits     <= (LEN_W+1)'(1);
      last_id   <= '0;
      have_last <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (enable && start) begin
            half      <= (BAUD_W+1)'(baud_in) + (BAUD_W+1)'(1);
            sel       <= sel_in;
            decode    <= decode_in;
            dly_l     <= dly_in;
            nbits     <= (LEN_W+1)'(len_in) + (LEN_W+1)'(1);
            last_id   <= new_id;
            have_last <= 1'b1;
            if (have_last && (last_id != new_id)) begin
              phase <= PH_SWITCH;
              dcnt  <= at_least_one(dly_in[3*DLY_W-1:2*DLY_W]);
            end else begin
              phase <= PH_LEAD;
              dcnt  <= at_least_one(dly_in[DLY_W-1:0]);
            end
          end
        end
        PH_SWITCH: begin
          if (expired) begin
            phase <= PH_LEAD;
            dcnt  <= at_least_one(dly_l[DLY_W-1:0]);
          end else begin
            dcnt <= dcnt - CNT_W'(1);
          end
        end
        PH_LEAD: begin
          if (expired) phase <= PH_CLOCK;
          else         dcnt  <= dcnt - CNT_W'(1);
        end
        PH_CLOCK: begin
          if (clk_done) begin
            phase <= PH_TRAIL;
            dcnt  <= at_least_one(dly_l[2*DLY_W-1:DLY_W]);
          end
        end
        PH_TRAIL: begin
          if (expired) begin
            phase <= PH_GAP;
            dcnt  <= gap_min;
          end else begin
            dcnt <= dcnt - CNT_W'(1);
          end
        end
        PH_GAP: begin
          if (expired) phase <= PH_IDLE;
          else         dcnt  <= dcnt - CNT_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sfc_sel_timer.sv
module sfc_sel_timer
  import sfc_sel_timer_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [30:0]      cfg_in,
  input  logic [31:0]      dly_in,
  input  logic             start,
  input  logic [LEN_W-1:0] nbits_m1,
  output logic             sclk,
  output logic [3:0]       cs_n,
  output logic             idle,
  output logic [31:0]      cfg_rd
);
  localparam int BAUD_W   = 4;
  localparam int BAUD_LSB = 19;
  localparam int CS_W     = 4;
  localparam int CS_LSB   = 10;
  localparam int DEC_BIT  = 9;
  localparam int EN_BIT   = 0;
  localparam int DLY_W    = 8;
  localparam int CNT_W    = ((DLY_W > BAUD_W + 2) ? DLY_W : BAUD_W + 2) + 1;

  phase_t            phase;
  logic              load_clk;
  logic              clk_done;
  logic [BAUD_W:0]   lat_half;
  logic [CS_W-1:0]   lat_sel;
  logic              lat_decode;
  logic [LEN_W:0]    lat_nbits;
  logic [CNT_W-1:0]  lat_gap_min;
  logic              in_clk_phase;
  logic              sel_active;

  assign in_clk_phase = (phase == PH_CLOCK);
  assign sel_active   = (phase == PH_LEAD) || (phase == PH_CLOCK) || (phase == PH_TRAIL);
  assign idle         = (phase == PH_IDLE);
  assign cfg_rd       = {idle, cfg_in};

  sfc_frame_fsm #(
    .BAUD_W(BAUD_W), .CS_W(CS_W), .DLY_W(DLY_W), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (cfg_in[EN_BIT]),
    .start     (start),
    .baud_in   (cfg_in[BAUD_LSB +: BAUD_W]),
    .sel_in    (cfg_in[CS_LSB +: CS_W]),
    .decode_in (cfg_in[DEC_BIT]),
    .dly_in    (dly_in),
    .len_in    (nbits_m1),
    .clk_done  (clk_done),
    .phase     (phase),
    .load_clk  (load_clk),
    .half      (lat_half),
    .sel       (lat_sel),
    .decode    (lat_decode),
    .nbits     (lat_nbits),
    .gap_min   (lat_gap_min)
  );

  sfc_clk_gen #(.BAUD_W(BAUD_W), .LEN_W(LEN_W)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load_clk),
    .run   (in_clk_phase),
    .half  (lat_half),
    .nbits (lat_nbits),
    .sclk  (sclk),
    .done  (clk_done)
  );

  sfc_sel_enc #(.CS_W(CS_W)) u_enc (
    .active (sel_active),
    .decode (lat_decode),
    .sel    (lat_sel),
    .cs_n   (cs_n)
  );
endmodule

// File: rtl/sfc_sel_timer_chk.sv
module sfc_sel_timer_chk #(
  parameter int CNT_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sclk,
  input logic [3:0]       cs_n,
  input logic             idle,
  input logic             in_clk_phase,
  input logic             lat_decode,
  input logic [4:0]       lat_half,
  input logic [CNT_W-1:0] lat_gap_min
);
  logic [5:0]     hi_cnt;
  logic [CNT_W:0] gap_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      gap_cnt <= '0;
    end else begin
      hi_cnt  <= sclk ? hi_cnt + 6'd1 : 6'd0;
      gap_cnt <= (cs_n == 4'hF && !idle) ? gap_cnt + (CNT_W+1)'(1) : '0;
    end
  end

  AST_SCLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> in_clk_phase); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (cs_n == 4'hF && !sclk)); // R10
  AST_ONEHOT_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_decode && cs_n != 4'hF) |-> ($countones(~cs_n) == 1)); // R4
  AST_SEL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != 4'hF && $past(cs_n) != 4'hF) |-> $stable(cs_n)); // R12
  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> (hi_cnt == {1'b0, lat_half})); // R2
  AST_MIN_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle) |-> (gap_cnt == (CNT_W+1)'(lat_gap_min) &&
                     gap_cnt >= (CNT_W+1)'({lat_half, 1'b0}))); // R9
endmodule

bind sfc_sel_timer sfc_sel_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sclk         (sclk),
  .cs_n         (cs_n),
  .idle         (idle),
  .in_clk_phase (in_clk_phase),
  .lat_decode   (lat_decode),
  .lat_half     (lat_half),
  .lat_gap_min  (lat_gap_min)
);

// File: tb/sfc_sel_timer_test.sv
`timescale 1ns/1ps
module sfc_sel_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [30:0] cfg_in = '0;
  logic [31:0] dly_in = '0;
  logic        start = 1'b0;
  logic [7:0]  nbits_m1 = '0;
  logic        sclk;
  logic [3:0]  cs_n;
  logic        idle;
  logic [31:0] cfg_rd;

  int n_checks = 0;
  int n_fail = 0;
  bit have_last = 0;
  int last_id = 0;

  always #2.5 clk = ~clk;

  sfc_sel_timer uut (
    .clk(clk), .rst_n(rst_n), .cfg_in(cfg_in), .dly_in(dly_in), .start(start),
    .nbits_m1(nbits_m1), .sclk(sclk), .cs_n(cs_n), .idle(idle), .cfg_rd(cfg_rd)
  );

  function automatic int floor1(int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int deselect_exp(int d, int baud);
    int per;
    per = 2 * (baud + 1);
    return (d > per) ? d : per;
  endfunction

  function automatic int pins_exp(int dec, int k);
    if (dec != 0) return k;
    return 4'hF & ~(1 << k);
  endfunction

  function automatic logic [30:0] ctrl_word(int baud, int cs, int dec, int en);
    logic [30:0] w;
    w = '0;
    w[22:19] = baud[3:0];
    w[13:10] = cs[3:0];
    w[9] = dec[0];
    w[0] = en[0];
    return w;
  endfunction

  task automatic chk(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_frame(int baud, int cs, int dec, int a, int b, int sd, int g,
                           int lenm1, int disturb);
    int pre = 0, lead = 0, low = 0, rises = 0, hi_run = 0, post = 0, cyc = 0;
    int csval = 15, busy_bit = 1, exp_pre;
    bit seen = 0, prev_s = 0, asserted;
    int id;
    id = dec * 16 + cs;
    exp_pre = (have_last && id != last_id) ? floor1(sd) : 0;
    have_last = 1;
    last_id = id;
    @(negedge clk);
    cfg_in = ctrl_word(baud, cs, dec, 1);
    dly_in = {g[7:0], sd[7:0], b[7:0], a[7:0]};
    nbits_m1 = lenm1[7:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busy_bit = cfg_rd[31];
    while (!idle && cyc < 60000) begin
      if (disturb != 0 && cyc == 3) begin
        cfg_in = ctrl_word((baud + 5) % 16, (cs + 1) % 4, 1 - dec, 0);
        dly_in = ~dly_in;
        nbits_m1 = ~nbits_m1;
      end
      asserted = (cs_n != 4'hF);
      if (sclk && !prev_s) rises++;
      if (asserted) begin
        if (!seen) csval = cs_n;
        seen = 1;
        low++;
        if (rises == 0 && !sclk) lead++;
        if (rises == 1 && sclk) hi_run++;
      end else if (!seen) pre++;
      else post++;
      prev_s = sclk;
      cyc++;
      @(negedge clk);
    end
    chk("R10 watchdog/busy flag", busy_bit, 0);
    chk("R10 frame ends", (cyc < 60000) ? 1 : 0, 1);
    chk(dec ? "R5 decoded select" : "R4 one-hot select", csval, pins_exp(dec, cs));
    chk("R8 switch gap", pre, exp_pre);
    chk("R6 lead time", lead, floor1(a) + baud + 1);
    chk("R7 select time", low, floor1(a) + 2 * (lenm1 + 1) * (baud + 1) + floor1(b));
    chk("R3 clock edges", rises, lenm1 + 1);
    chk("R2 half period", hi_run, baud + 1);
    chk("R9 deselect time", post, deselect_exp(g, baud));
  endtask

  task automatic ignored_start(string req);
    int busy = 0, selc = 0, clkc = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (!idle) busy++;
      if (cs_n != 4'hF) selc++;
      if (sclk) clkc++;
      @(negedge clk);
    end
    chk(req, busy + selc + clkc, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int seed, baud, dec, cs;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    chk("R1 idle", idle, 1);
    chk("R1 cs_n", cs_n, 15);
    chk("R1 sclk", sclk, 0);
    chk("R1 read-back idle", cfg_rd[31], 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", idle, 1);
    cfg_in = ctrl_word(3, 2, 0, 1);
    @(negedge clk);
    chk("R10 echo", cfg_rd[30:0], ctrl_word(3, 2, 0, 1));

    run_frame(0, 0, 0, 0, 0, 0, 0, 0, 0);
    run_frame(15, 0, 0, 255, 255, 255, 255, 255, 0);
    run_frame(7, 3, 0, 2, 3, 9, 1, 4, 0);
    run_frame(7, 3, 0, 1, 1, 9, 0, 2, 0);
    run_frame(2, 9, 1, 4, 2, 0, 40, 3, 0);
    run_frame(1, 14, 1, 3, 5, 6, 2, 7, 0);
    run_frame(1, 14, 1, 3, 5, 6, 2, 1, 0);

    for (int n = 0; n < 24; n++) begin
      baud = $urandom % 16;
      dec = $urandom % 2;
      cs = dec ? ($urandom % 15) : ($urandom % 4);
      run_frame(baud, cs, dec, $urandom % 40, $urandom % 40, $urandom % 40,
                $urandom % 40, $urandom % 12, 0);
    end

    run_frame(4, 1, 0, 6, 7, 8, 3, 5, 1);
    ignored_start("R11 start ignored while disabled");
    cfg_in = ctrl_word(4, 1, 0, 1);
    run_frame(4, 1, 0, 2, 2, 2, 2, 1, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule